// File: doc/BRIEF.md
# Two-level breakpoint trigger unit

This block watches a processor as it runs and raises a one-cycle breakpoint trigger when a programmed combination of comparator hits occurs. One input reports each retired instruction with its program counter. Another reports each data-bus access with its address, size, direction and data. Four program-counter comparators are ORed into one PC term; only comparator 0 has a don't-care mask. An address comparator checks an inclusive window, either inside or outside it, and can also require a given direction and access size. A data comparator with a don't-care mask picks the operand bytes from the bus according to access size and the low address bits. It can optionally gate the address term.

A small sequencer combines the PC term and the qualified address term. It supports three single-level forms and two ordered two-level forms. While a two-level form waits for its second condition, a level output is high. Software configures everything through a plain register write port. The observation inputs are plain strobes, not handshakes. The unit never applies back-pressure: it looks at every strobe in the cycle it is presented and cannot stall the core.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset every register is zero, `trig_o` and `level_o` are low, and no strobe causes a trigger.
- R2: The PC term is the OR of comparators whose enable bit is set. Comparator k value sits at register k (0..3). Comparator 0 ignores the PC bits set in register 4. Comparators 1 to 3 need an exact match. The enables are mode-register bits 8:5, with bit 5 for comparator 0.
- R3: The address window uses register 5 as the lower bound and register 6 as the upper bound, both inclusive. Mode bit 4 = 0 hits inside the window; mode bit 4 = 1 hits strictly below the lower bound or strictly above the upper bound.
- R4: Register 7 holds the qualifiers. Bit 0 enables the direction check, and bit 1 is the required direction (1 = write). Bit 2 enables the size check, and bits 4:3 are the required size. A disabled check accepts any access.
- R5: Size codes on `bus_size` are 0 = byte, 1 = word, 2 = longword. A byte access compares data bits 31:24, 23:16, 15:8 or 7:0 for address low bits 00, 01, 10 or 11. A word access compares bits 31:16 when address bit 1 is 0, and bits 15:0 when it is 1. A longword access compares bits 31:0. The selected operand is right-aligned against register 8.
- R6: Data bits set in register 9 are ignored. When mode bit 3 is set, an address hit counts only if the data also matches. When mode bit 3 is clear, the data has no effect.
- R7: Mode bits 2:0 choose the form: 1 = PC only, 2 = qualified address only, 3 = either. Codes 0, 6 and 7 never trigger.
- R8: In form 4, a PC hit sets `level_o`. A later qualified address hit then pulses `trig_o` and returns `level_o` to low. Further PC hits while `level_o` is high change nothing.
- R9: In form 5, a qualified address hit sets `level_o`. A later PC hit then pulses `trig_o` and returns `level_o` to low.
- R10: A second-level hit in the same cycle as the arming hit does not fire. The unit only arms.
- R11: Any write to the mode register (register 10) clears `level_o` and `trig_o` on the next cycle. The new form applies from then on.
- R12: `trig_o` is high in the cycle after the strobe that completes the condition. It lasts one cycle per such strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| pc_valid | input | 1 | A retired instruction is reported this cycle |
| pc_value | input | 32 | Program counter of that instruction |
| bus_valid | input | 1 | A data-bus access is reported this cycle |
| bus_addr | input | 32 | Access address |
| bus_size | input | 2 | Access size code |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_data | input | 32 | Data on the bus, byte lanes 31:24 down to 7:0 |
| trig_o | output | 1 | One-cycle breakpoint trigger |
| level_o | output | 1 | High while a two-level form waits for its second condition |

## Verification
The assertions check several properties on every cycle. The exact comparators hit only on equal PC values. An inside-window hit lies within the bounds. `level_o` is high only under a two-level form. A trigger always follows a strobe, and form 0 or an unarmed two-level form never fires. A mode write always clears the sequencer. Other behaviours can only be shown by the bench's scenarios, because they depend on chosen values: the mask and lane arithmetic, the outside window edges, the qualifier combinations, the ordering of the two-level forms and the same-cycle rule.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [2:0] {
    TM_OFF          = 3'd0,
    TM_PC           = 3'd1,
    TM_ADDR         = 3'd2,
    TM_EITHER       = 3'd3,
    TM_PC_THEN_ADDR = 3'd4,
    TM_ADDR_THEN_PC = 3'd5
  } trig_form_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } acc_size_e;

  // Fixed field positions inside the mode register
  localparam int MODE_FORM_LSB = 0;
  localparam int MODE_DQ_BIT   = 3;
  localparam int MODE_OUT_BIT  = 4;
  localparam int MODE_EN_LSB   = 5;

  // Qualifier register layout
  localparam int QUAL_W = 5;

  function automatic logic is_two_level(input trig_form_e f);
    return (f == TM_PC_THEN_ADDR) || (f == TM_ADDR_THEN_PC);
  endfunction

endpackage

// File: rtl/dbg_trig_pc_cmp.sv
module dbg_trig_pc_cmp #(
  parameter int NPC = 4,
  parameter int PCW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pc_valid_i,
  input  logic [PCW-1:0]           pc_value_i,
  input  logic [NPC-1:0][PCW-1:0]  cmp_val_i,
  input  logic [PCW-1:0]           mask0_i,
  input  logic [NPC-1:0]           cmp_en_i,
  output logic                     pc_hit_o
);

  logic [NPC-1:0] lane_hit;

  for (genvar k = 0; k < NPC; k++) begin : g_cmp
    if (k == 0) begin : g_masked
      assign lane_hit[k] = pc_valid_i && cmp_en_i[k] &&
                           (((pc_value_i ^ cmp_val_i[k]) & ~mask0_i) == '0);
    end else begin : g_exact
      assign lane_hit[k] = pc_valid_i && cmp_en_i[k] &&
                           (pc_value_i == cmp_val_i[k]);

      // R2: exact comparators never hit on an unequal PC
      p_exact_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lane_hit[k] |-> (pc_valid_i && (pc_value_i == cmp_val_i[k])));
    end
  end

  assign pc_hit_o = |lane_hit;

endmodule

// File: rtl/dbg_trig_bus_cmp.sv
module dbg_trig_bus_cmp
  import dbg_trig_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [1:0]        bus_size_i,
  input  logic              bus_write_i,
  input  logic [31:0]       bus_data_i,
  input  logic [AW-1:0]     low_i,
  input  logic [AW-1:0]     high_i,
  input  logic              outside_i,
  input  logic [QUAL_W-1:0] qual_i,
  input  logic [31:0]       dval_i,
  input  logic [31:0]       dmask_i,
  output logic              addr_hit_o,
  output logic              data_hit_o
);

  logic        in_win, win_ok, dir_ok, size_ok;
  logic [31:0] opnd, lane_mask;

  assign in_win  = (bus_addr_i >= low_i) && (bus_addr_i <= high_i);
  assign win_ok  = outside_i ? !in_win : in_win;
  assign dir_ok  = !qual_i[0] || (bus_write_i == qual_i[1]);
  assign size_ok = !qual_i[2] || (bus_size_i == qual_i[4:3]);

  assign addr_hit_o = bus_valid_i && win_ok && dir_ok && size_ok;

  // Operand lane selection by access size and low address bits
  always_comb begin
    unique case (acc_size_e'(bus_size_i))
      SZ_BYTE: begin
        lane_mask = 32'h0000_00FF;
        unique case (bus_addr_i[1:0])
          2'b00:   opnd = {24'h0, bus_data_i[31:24]};
          2'b01:   opnd = {24'h0, bus_data_i[23:16]};
          2'b10:   opnd = {24'h0, bus_data_i[15:8]};
          default: opnd = {24'h0, bus_data_i[7:0]};
        endcase
      end
      SZ_WORD: begin
        lane_mask = 32'h0000_FFFF;
        opnd = bus_addr_i[1] ? {16'h0, bus_data_i[15:0]}
                             : {16'h0, bus_data_i[31:16]};
      end
      default: begin
        lane_mask = 32'hFFFF_FFFF;
        opnd      = bus_data_i;
      end
    endcase
  end

  assign data_hit_o = (((opnd ^ dval_i) & lane_mask & ~dmask_i) == '0);

  // R3: an inside-window hit always lies within the inclusive bounds
  p_inside_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit_o && !outside_i) |-> ((bus_addr_i >= low_i) && (bus_addr_i <= high_i)));

  // R4: a hit with the direction check enabled carries the required direction
  p_dir_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit_o && qual_i[0]) |-> (bus_write_i == qual_i[1]));

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr_i,
  input  trig_form_e form_i,
  input  logic       pc_hit_i,
  input  logic       adr_hit_i,
  input  logic       strobe_i,
  output logic       trig_o,
  output logic       level_o
);

  logic armed_q, armed_d, fire_d, trig_q;

  always_comb begin
    fire_d  = 1'b0;
    armed_d = armed_q;
    unique case (form_i)
      TM_PC:     fire_d = pc_hit_i;
      TM_ADDR:   fire_d = adr_hit_i;
      TM_EITHER: fire_d = pc_hit_i || adr_hit_i;
      TM_PC_THEN_ADDR: begin
        if (!armed_q) armed_d = pc_hit_i;
        else if (adr_hit_i) begin
          fire_d  = 1'b1;
          armed_d = 1'b0;
        end
      end
      TM_ADDR_THEN_PC: begin
        if (!armed_q) armed_d = adr_hit_i;
        else if (pc_hit_i) begin
          fire_d  = 1'b1;
          armed_d = 1'b0;
        end
      end
      default: armed_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr_i) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      trig_q  <= fire_d;
    end
  end

  assign trig_o  = trig_q;
  assign level_o = armed_q;

  // R11: a mode write always leaves the sequencer idle
  p_mode_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> (!level_o && !trig_o));

  // R8: level is only ever held under a two-level form
  p_level_two_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level_o |-> is_two_level(form_i));

  // R10: an unarmed two-level form cannot fire in the next cycle
  p_no_fire_unarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_two_level(form_i) && !level_o && !mode_wr_i) |=> !trig_o);

  // R12: a disabled form never fires; every trigger follows a strobe
  p_off_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (form_i == TM_OFF) |=> !trig_o);

  p_trig_after_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i) |=> !trig_o);

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int NPC = 4,
  parameter int PCW = 32,
  parameter int AW  = 32,
  parameter int CAW = $clog2(NPC + 7)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  input  logic           pc_valid,
  input  logic [PCW-1:0] pc_value,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic [1:0]     bus_size,
  input  logic           bus_write,
  input  logic [31:0]    bus_data,
  output logic           trig_o,
  output logic           level_o
);

  // Register indices derived from the comparator count
  localparam int REG_MASK0 = NPC;
  localparam int REG_LOW   = NPC + 1;
  localparam int REG_HIGH  = NPC + 2;
  localparam int REG_QUAL  = NPC + 3;
  localparam int REG_DVAL  = NPC + 4;
  localparam int REG_DMASK = NPC + 5;
  localparam int REG_MODE  = NPC + 6;
  localparam int MODE_W    = MODE_EN_LSB + NPC;

  logic [NPC-1:0][PCW-1:0] pc_val_q;
  logic [PCW-1:0]          mask0_q;
  logic [AW-1:0]           low_q, high_q;
  logic [QUAL_W-1:0]       qual_q;
  logic [31:0]             dval_q, dmask_q;
  logic [MODE_W-1:0]       mode_q;
  logic                    mode_wr;

  assign mode_wr = cfg_we && (cfg_addr == CAW'(REG_MODE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_val_q <= '0;
      mask0_q  <= '0;
      low_q    <= '0;
      high_q   <= '0;
      qual_q   <= '0;
      dval_q   <= '0;
      dmask_q  <= '0;
      mode_q   <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < NPC; k++) begin
        if (cfg_addr == CAW'(k)) pc_val_q[k] <= cfg_wdata[PCW-1:0];
      end
      if (cfg_addr == CAW'(REG_MASK0)) mask0_q <= cfg_wdata[PCW-1:0];
      if (cfg_addr == CAW'(REG_LOW))   low_q   <= cfg_wdata[AW-1:0];
      if (cfg_addr == CAW'(REG_HIGH))  high_q  <= cfg_wdata[AW-1:0];
      if (cfg_addr == CAW'(REG_QUAL))  qual_q  <= cfg_wdata[QUAL_W-1:0];
      if (cfg_addr == CAW'(REG_DVAL))  dval_q  <= cfg_wdata;
      if (cfg_addr == CAW'(REG_DMASK)) dmask_q <= cfg_wdata;
      if (mode_wr)                     mode_q  <= cfg_wdata[MODE_W-1:0];
    end
  end

  logic pc_hit, adr_raw, data_hit, adr_qual;

  dbg_trig_pc_cmp #(.NPC(NPC), .PCW(PCW)) i_pc_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_valid_i (pc_valid),
    .pc_value_i (pc_value),
    .cmp_val_i  (pc_val_q),
    .mask0_i    (mask0_q),
    .cmp_en_i   (mode_q[MODE_EN_LSB +: NPC]),
    .pc_hit_o   (pc_hit)
  );

  dbg_trig_bus_cmp #(.AW(AW)) i_bus_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid_i (bus_valid),
    .bus_addr_i  (bus_addr),
    .bus_size_i  (bus_size),
    .bus_write_i (bus_write),
    .bus_data_i  (bus_data),
    .low_i       (low_q),
    .high_i      (high_q),
    .outside_i   (mode_q[MODE_OUT_BIT]),
    .qual_i      (qual_q),
    .dval_i      (dval_q),
    .dmask_i     (dmask_q),
    .addr_hit_o  (adr_raw),
    .data_hit_o  (data_hit)
  );

  assign adr_qual = adr_raw && (!mode_q[MODE_DQ_BIT] || data_hit);

  dbg_trig_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr_i (mode_wr),
    .form_i    (trig_form_e'(mode_q[MODE_FORM_LSB +: 3])),
    .pc_hit_i  (pc_hit),
    .adr_hit_i (adr_qual),
    .strobe_i  (pc_valid || bus_valid),
    .trig_o    (trig_o),
    .level_o   (level_o)
  );

endmodule

// File: tb/test_dbg_trig_unit.sv
module test_dbg_trig_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        pc_valid;
  logic [31:0] pc_value;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_write;
  logic [31:0] bus_data;
  logic        trig_o, level_o;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dbg_trig_unit i_dbg_trig_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pc_valid(pc_valid), .pc_value(pc_value),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_write(bus_write), .bus_data(bus_data), .trig_o(trig_o), .level_o(level_o)
  );

  localparam logic [3:0] R_MASK0 = 4, R_LOW = 5, R_HIGH = 6, R_QUAL = 7,
                         R_DVAL = 8, R_DMASK = 9, R_MODE = 10;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One cycle of stimulus; outputs are sampled on the following falling edge
  task automatic step(input logic pv, input logic [31:0] pc,
                      input logic bv, input logic [31:0] a, input logic [1:0] sz,
                      input logic w, input logic [31:0] d);
    @(negedge clk);
    pc_valid = pv; pc_value = pc;
    bus_valid = bv; bus_addr = a; bus_size = sz; bus_write = w; bus_data = d;
    @(negedge clk);
    pc_valid = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic pc_ev(input logic [31:0] pc);
    step(1'b1, pc, 1'b0, 32'h0, 2'd2, 1'b0, 32'h0);
  endtask

  task automatic bus_ev(input logic [31:0] a, input logic [1:0] sz,
                        input logic w, input logic [31:0] d);
    step(1'b0, 32'h0, 1'b1, a, sz, w, d);
  endtask

  task automatic idle();
    step(1'b0, 32'h0, 1'b0, 32'h0, 2'd2, 1'b0, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1", "trig after reset", trig_o, 0);
    chk("R1", "level after reset", level_o, 0);
    step(1'b1, 32'h0, 1'b1, 32'h0, 2'd2, 1'b0, 32'h0);
    chk("R1", "no trigger from reset config", trig_o, 0);
  endtask

  task automatic t_pc();
    wr(0, 32'h1000); wr(R_MASK0, 32'hF);
    wr(1, 32'h2000); wr(2, 32'h3000); wr(3, 32'h4000);
    wr(R_MODE, 32'h1 | (32'hF << 5));
    pc_ev(32'h100A); chk("R2", "masked comparator 0 hit", trig_o, 1);
    idle();          chk("R12", "pulse lasts one cycle", trig_o, 0);
    pc_ev(32'h2004); chk("R2", "exact comparator ignores near miss", trig_o, 0);
    pc_ev(32'h4000); chk("R2", "comparator 3 hit", trig_o, 1);
    wr(R_MODE, 32'h1 | (32'h7 << 5));
    pc_ev(32'h4000); chk("R2", "disabled comparator 3", trig_o, 0);
    pc_ev(32'h3000); chk("R2", "comparator 2 still enabled", trig_o, 1);
  endtask

  task automatic t_range();
    wr(R_LOW, 32'h100); wr(R_HIGH, 32'h1FF); wr(R_QUAL, 0);
    wr(R_MODE, 32'h2);
    bus_ev(32'h100, 2'd2, 0, 0); chk("R3", "lower bound inclusive", trig_o, 1);
    bus_ev(32'h1FF, 2'd2, 0, 0); chk("R3", "upper bound inclusive", trig_o, 1);
    bus_ev(32'h0FF, 2'd2, 0, 0); chk("R3", "below window", trig_o, 0);
    bus_ev(32'h200, 2'd2, 0, 0); chk("R3", "above window", trig_o, 0);
    wr(R_MODE, 32'h2 | 32'h10);
    bus_ev(32'h0FF, 2'd2, 0, 0); chk("R3", "outside below", trig_o, 1);
    bus_ev(32'h200, 2'd2, 0, 0); chk("R3", "outside above", trig_o, 1);
    bus_ev(32'h100, 2'd2, 0, 0); chk("R3", "outside excludes bound", trig_o, 0);
  endtask

  task automatic t_qual();
    wr(R_LOW, 0); wr(R_HIGH, 32'hFFFF_FFFF); wr(R_MODE, 32'h2);
    wr(R_QUAL, 32'h3);
    bus_ev(32'h10, 2'd2, 0, 0); chk("R4", "read rejected", trig_o, 0);
    bus_ev(32'h10, 2'd2, 1, 0); chk("R4", "write accepted", trig_o, 1);
    wr(R_QUAL, 32'h4 | (32'h1 << 3));
    bus_ev(32'h10, 2'd0, 0, 0); chk("R4", "byte rejected", trig_o, 0);
    bus_ev(32'h10, 2'd1, 0, 0); chk("R4", "word accepted", trig_o, 1);
    wr(R_QUAL, 0);
  endtask

  task automatic t_data();
    wr(R_LOW, 0); wr(R_HIGH, 32'hFFFF_FFFF); wr(R_QUAL, 0);
    wr(R_DMASK, 0); wr(R_DVAL, 32'hAB);
    wr(R_MODE, 32'h2 | 32'h8);
    bus_ev(32'h1, 2'd0, 0, 32'h00AB_0000); chk("R5", "byte lane 23:16", trig_o, 1);
    bus_ev(32'h0, 2'd0, 0, 32'h00AB_0000); chk("R5", "byte lane 31:24 mismatch", trig_o, 0);
    bus_ev(32'h3, 2'd0, 0, 32'h0000_00AB); chk("R5", "byte lane 7:0", trig_o, 1);
    wr(R_DVAL, 32'h1234);
    bus_ev(32'h2, 2'd1, 0, 32'h0000_1234); chk("R5", "word low half", trig_o, 1);
    bus_ev(32'h0, 2'd1, 0, 32'h0000_1234); chk("R5", "word high half mismatch", trig_o, 0);
    bus_ev(32'h0, 2'd1, 0, 32'h1234_0000); chk("R5", "word high half", trig_o, 1);
    wr(R_DVAL, 32'hDEAD_BEEF);
    bus_ev(32'h0, 2'd2, 0, 32'hDEAD_BEEF); chk("R5", "longword match", trig_o, 1);
    bus_ev(32'h0, 2'd2, 0, 32'hDEAD_BEEE); chk("R6", "data mismatch blocks", trig_o, 0);
    wr(R_DMASK, 32'h1);
    bus_ev(32'h0, 2'd2, 0, 32'hDEAD_BEEE); chk("R6", "masked bit ignored", trig_o, 1);
    wr(R_DMASK, 0); wr(R_MODE, 32'h2);
    bus_ev(32'h0, 2'd2, 0, 32'h0); chk("R6", "data ignored when not qualifying", trig_o, 1);
  endtask

  task automatic t_either();
    wr(0, 32'h500); wr(R_MASK0, 0);
    wr(R_LOW, 32'h800); wr(R_HIGH, 32'h8FF);
    wr(R_MODE, 32'h3 | (32'h1 << 5));
    pc_ev(32'h500);              chk("R7", "either: PC side", trig_o, 1);
    bus_ev(32'h840, 2'd2, 0, 0); chk("R7", "either: address side", trig_o, 1);
    step(1'b1, 32'h504, 1'b1, 32'h900, 2'd2, 0, 0);
    chk("R7", "either: neither", trig_o, 0);
  endtask

  task automatic t_pc_then_addr();
    wr(R_MODE, 32'h4 | (32'h1 << 5));
    bus_ev(32'h840, 2'd2, 0, 0); chk("R8", "address before arm", trig_o, 0);
    chk("R8", "still level one", level_o, 0);
    pc_ev(32'h500); chk("R8", "arm no trigger", trig_o, 0);
    chk("R8", "armed level", level_o, 1);
    pc_ev(32'h500); chk("R8", "repeat PC keeps level", level_o, 1);
    bus_ev(32'h840, 2'd2, 0, 0); chk("R8", "second level fires", trig_o, 1);
    chk("R8", "back to level one", level_o, 0);
    idle(); chk("R12", "two-level pulse one cycle", trig_o, 0);
  endtask

  task automatic t_addr_then_pc();
    wr(R_MODE, 32'h5 | (32'h1 << 5));
    pc_ev(32'h500); chk("R9", "PC before arm", trig_o, 0);
    bus_ev(32'h840, 2'd2, 0, 0); chk("R9", "armed by address", level_o, 1);
    pc_ev(32'h500); chk("R9", "PC fires", trig_o, 1);
    chk("R9", "level returns", level_o, 0);
  endtask

  task automatic t_same_cycle();
    wr(R_MODE, 32'h4 | (32'h1 << 5));
    step(1'b1, 32'h500, 1'b1, 32'h840, 2'd2, 0, 0);
    chk("R10", "same-cycle second term ignored", trig_o, 0);
    chk("R10", "armed instead", level_o, 1);
    bus_ev(32'h840, 2'd2, 0, 0); chk("R10", "fires on later address", trig_o, 1);
  endtask

  task automatic t_mode_write();
    wr(R_MODE, 32'h4 | (32'h1 << 5));
    pc_ev(32'h500); chk("R11", "armed before rewrite", level_o, 1);
    wr(R_MODE, 32'h4 | (32'h1 << 5));
    chk("R11", "rewrite clears level", level_o, 0);
    bus_ev(32'h840, 2'd2, 0, 0); chk("R11", "no fire after clear", trig_o, 0);
  endtask

  task automatic t_off();
    wr(R_MODE, 32'h0 | (32'h1 << 5));
    step(1'b1, 32'h500, 1'b1, 32'h840, 2'd2, 0, 0);
    chk("R12", "form 0 silent", trig_o, 0);
    wr(R_MODE, 32'h7 | (32'h1 << 5));
    step(1'b1, 32'h500, 1'b1, 32'h840, 2'd2, 0, 0);
    chk("R7", "form 7 silent", trig_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pc_valid = 1'b0; pc_value = '0; bus_valid = 1'b0; bus_addr = '0;
    bus_size = 2'd2; bus_write = 1'b0; bus_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pc();
    t_range();
    t_qual();
    t_data();
    t_either();
    t_pc_then_addr();
    t_addr_then_pc();
    t_same_cycle();
    t_mode_write();
    t_off();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule